// File: doc/BRIEF.md
# Multi-PHY Poll Responder

This block sits on the PHY side of a multi-port cell bus. An ATM-layer master polls it by presenting 5-bit port addresses on separate transmit and receive address buses. For every address that the block owns, it answers on a single cell-available line for each direction, one clock later. The transmit answer reflects free space for that port and the receive answer reflects a waiting cell, both taken from per-port availability vectors that internal queues supply. For any other address the line is released, with its output enable low, so that other devices on the shared line can answer.

Ownership comes from a 31-bit connected-ports mask. The mask is all ones after reset, so every address from 0 to 30 is answered. Address 31 is a null address and is never answered. When the master lowers a direction's active-low enable, the block checks the address polled in the cycle before. If that address is connected, it latches it as the selected port for the coming cell transfer. Otherwise it marks the direction as not selected. The transmit and receive sides are decoded independently.

Top module: `poll_responder`

## Requirements
- R1: After reset, both output enables and both cell-available lines are low, neither side reports a selection, each selected-port output reads 31, and the mask is all ones.
- R2: An address presented in clock cycle n drives the matching output enable high in cycle n+1 if that address's bit is set in the mask (bit k belongs to address k).
- R3: Address 31 never raises the output enable, whatever the mask and the availability vectors hold.
- R4: An address whose mask bit is clear leaves the output enable and the cell-available line low in the following cycle.
- R5: While the output enable is high, the cell-available line equals availability bit k of the polled address k. While the output enable is low, the cell-available line is low.
- R6: A mask write (mask_we_i high at a clock edge) loads mask_i. An address sampled at that same edge still uses the old mask, and addresses sampled at later edges use the new one.
- R7: If a side's enable is high at one clock edge and low at the next, and the address sampled at the earlier edge was connected, then after the later edge the side reports a selection with that address as the selected port.
- R8: On the same enable falling transition with an unconnected or null previous address, the side reports no selection and its selected-port output reads 31.
- R9: The transmit and receive sides use their own address, enable and availability inputs, and activity on one side does not change the outputs of the other.
- R10: The selection outputs change only on an enable falling transition. They hold while the enable stays low or stays high, even as the address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Load strobe for the connected-ports mask |
| mask_i | input | 31 | New connected-ports mask, bit k for address k |
| tx_addr_i | input | 5 | Transmit poll/select address |
| tx_enb_ni | input | 1 | Transmit enable, active low |
| tx_space_i | input | 31 | Per-port transmit space available |
| tx_clav_o | output | 1 | Transmit cell-available line 0 |
| tx_clav_oe_o | output | 1 | Output enable for tx_clav_o |
| tx_sel_valid_o | output | 1 | Transmit port selected |
| tx_sel_port_o | output | 5 | Selected transmit port, 31 when none |
| rx_addr_i | input | 5 | Receive poll/select address |
| rx_enb_ni | input | 1 | Receive enable, active low |
| rx_cell_i | input | 31 | Per-port receive cell waiting |
| rx_clav_o | output | 1 | Receive cell-available line 0 |
| rx_clav_oe_o | output | 1 | Output enable for rx_clav_o |
| rx_sel_valid_o | output | 1 | Receive port selected |
| rx_sel_port_o | output | 5 | Selected receive port, 31 when none |

## Verification
The bench polls all 31 addresses with a mixed availability pattern. A design with an off-by-one latency or a swapped index would return the wrong bit or answer in the wrong cycle. It polls address 31 with the mask and availability all ones, which catches a decoder that treats the null address as a port. It polls an address in the same cycle as a mask write: a design that applies the new mask too early would go silent one poll too soon. It also drops the enable after polls of connected and masked addresses and then keeps it low while the address moves on, which exposes a design that selects the wrong address, keeps a stale selection, or re-latches while the enable stays low.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int ADDR_W    = 5;
  localparam int NUM_PORTS = 31;
endpackage

// File: rtl/poll_mask.sv
module poll_mask #(
  parameter int NUM_PORTS = poll_pkg::NUM_PORTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  output logic [NUM_PORTS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '1;
    else if (we_i) mask_o <= mask_i;
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o)); // R6
endmodule

// File: rtl/poll_side.sv
module poll_side #(
  parameter int ADDR_W    = poll_pkg::ADDR_W,
  parameter int NUM_PORTS = poll_pkg::NUM_PORTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PORTS-1:0] avail_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  output logic                 clav_o,
  output logic                 clav_oe_o,
  output logic [ADDR_W-1:0]    last_addr_o
);
  localparam int SPAN = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] NULL_ADDR = ADDR_W'(SPAN - 1);

  logic [SPAN-1:0] mask_ext, avail_ext;
  logic            hit_d;

  // ports beyond NUM_PORTS, including the null address, decode as unconnected
  assign mask_ext  = SPAN'(mask_i);
  assign avail_ext = SPAN'(avail_i);
  assign hit_d     = mask_ext[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o <= NULL_ADDR;
      clav_oe_o   <= 1'b0;
      clav_o      <= 1'b0;
    end else begin
      last_addr_o <= addr_i;
      clav_oe_o   <= hit_d;
      clav_o      <= hit_d & avail_ext[addr_i];
    end
  end

  AST_NULL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == NULL_ADDR) |=> !clav_oe_o); // R3
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) < NUM_PORTS && !mask_ext[addr_i]) |=> (!clav_oe_o && !clav_o)); // R4
  AST_QUIET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clav_oe_o |-> !clav_o); // R5
endmodule

// File: rtl/poll_sel.sv
module poll_sel #(
  parameter int ADDR_W = poll_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enb_ni,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_valid_o,
  output logic [ADDR_W-1:0] sel_port_o
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  logic enb_q, fall;
  assign fall = enb_q & ~enb_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enb_q       <= 1'b1;
      sel_valid_o <= 1'b0;
      sel_port_o  <= NULL_ADDR;
    end else begin
      enb_q <= enb_ni;
      if (fall) begin
        sel_valid_o <= hit_i;
        sel_port_o  <= hit_i ? addr_i : NULL_ADDR;
      end
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> ($stable(sel_valid_o) && $stable(sel_port_o))); // R10
  AST_SEL_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !hit_i) |=> !sel_valid_o); // R8
  AST_SEL_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_port_o == NULL_ADDR)); // R8
endmodule

// File: rtl/poll_responder.sv
module poll_responder #(
  parameter int ADDR_W    = poll_pkg::ADDR_W,
  parameter int NUM_PORTS = poll_pkg::NUM_PORTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mask_we_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  input  logic [ADDR_W-1:0]    tx_addr_i,
  input  logic                 tx_enb_ni,
  input  logic [NUM_PORTS-1:0] tx_space_i,
  output logic                 tx_clav_o,
  output logic                 tx_clav_oe_o,
  output logic                 tx_sel_valid_o,
  output logic [ADDR_W-1:0]    tx_sel_port_o,
  input  logic [ADDR_W-1:0]    rx_addr_i,
  input  logic                 rx_enb_ni,
  input  logic [NUM_PORTS-1:0] rx_cell_i,
  output logic                 rx_clav_o,
  output logic                 rx_clav_oe_o,
  output logic                 rx_sel_valid_o,
  output logic [ADDR_W-1:0]    rx_sel_port_o
);
  logic [NUM_PORTS-1:0] mask_q;
  logic [ADDR_W-1:0]    tx_last, rx_last;

  poll_mask #(.NUM_PORTS(NUM_PORTS)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i), .mask_i, .mask_o(mask_q)
  );

  poll_side #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_tx_side (
    .clk_i, .rst_ni, .addr_i(tx_addr_i), .avail_i(tx_space_i), .mask_i(mask_q),
    .clav_o(tx_clav_o), .clav_oe_o(tx_clav_oe_o), .last_addr_o(tx_last)
  );

  poll_side #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_rx_side (
    .clk_i, .rst_ni, .addr_i(rx_addr_i), .avail_i(rx_cell_i), .mask_i(mask_q),
    .clav_o(rx_clav_o), .clav_oe_o(rx_clav_oe_o), .last_addr_o(rx_last)
  );

  poll_sel #(.ADDR_W(ADDR_W)) u_tx_sel (
    .clk_i, .rst_ni, .enb_ni(tx_enb_ni), .hit_i(tx_clav_oe_o), .addr_i(tx_last),
    .sel_valid_o(tx_sel_valid_o), .sel_port_o(tx_sel_port_o)
  );

  poll_sel #(.ADDR_W(ADDR_W)) u_rx_sel (
    .clk_i, .rst_ni, .enb_ni(rx_enb_ni), .hit_i(rx_clav_oe_o), .addr_i(rx_last),
    .sel_valid_o(rx_sel_valid_o), .sel_port_o(rx_sel_port_o)
  );

  AST_TX_SEL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_sel_valid_o) |-> $past(tx_clav_oe_o)); // R7
  AST_RX_SEL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_sel_valid_o) |-> $past(rx_clav_oe_o)); // R7
endmodule

// File: tb/tb_poll_responder.sv
module tb_poll_responder;
  logic        clk = 0, rst_ni = 0;
  logic        mask_we = 0;
  logic [30:0] mask = '0;
  logic [4:0]  tx_addr = 5'd31, rx_addr = 5'd31;
  logic        tx_enb = 1, rx_enb = 1;
  logic [30:0] tx_space = '0, rx_cell = '0;
  logic        tx_clav, tx_oe, tx_sv, rx_clav, rx_oe, rx_sv;
  logic [4:0]  tx_sp, rx_sp;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  poll_responder dut (
    .clk_i(clk), .rst_ni, .mask_we_i(mask_we), .mask_i(mask),
    .tx_addr_i(tx_addr), .tx_enb_ni(tx_enb), .tx_space_i(tx_space),
    .tx_clav_o(tx_clav), .tx_clav_oe_o(tx_oe), .tx_sel_valid_o(tx_sv), .tx_sel_port_o(tx_sp),
    .rx_addr_i(rx_addr), .rx_enb_ni(rx_enb), .rx_cell_i(rx_cell),
    .rx_clav_o(rx_clav), .rx_clav_oe_o(rx_oe), .rx_sel_valid_o(rx_sv), .rx_sel_port_o(rx_sp)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 tx_oe", tx_oe, 0);   chk("R1 rx_oe", rx_oe, 0);
    chk("R1 tx_clav", tx_clav, 0); chk("R1 rx_clav", rx_clav, 0);
    chk("R1 tx_sv", tx_sv, 0);   chk("R1 rx_sv", rx_sv, 0);
    chk("R1 tx_sp", tx_sp, 31);  chk("R1 rx_sp", rx_sp, 31);
  endtask

  // R1 default mask, R2 latency, R5 availability value
  task automatic t_all_ports();
    tx_space = 31'h2A5C_93E1;
    rx_cell  = ~31'h2A5C_93E1;
    for (int k = 0; k < 31; k++) begin
      tx_addr = 5'(k); rx_addr = 5'(30 - k);
      step();
      chk("R2 tx_oe", tx_oe, 1);
      chk("R5 tx_clav", tx_clav, int'(tx_space[k]));
      chk("R1 rx_oe", rx_oe, 1);
      chk("R5 rx_clav", rx_clav, int'(rx_cell[30 - k]));
    end
  endtask

  task automatic t_null();
    tx_space = '1; rx_cell = '1;
    tx_addr = 5'd31; rx_addr = 5'd31;
    step();
    chk("R3 tx_oe", tx_oe, 0); chk("R3 rx_oe", rx_oe, 0);
    chk("R5 tx_clav quiet", tx_clav, 0);
  endtask

  // R4, R6: mask write, same-edge poll still uses old mask
  task automatic t_mask();
    mask = ~(31'(1) << 6 | 31'(1) << 10);
    mask_we = 1; tx_addr = 5'd6; rx_addr = 5'd10;
    step();
    mask_we = 0;
    chk("R6 old mask tx", tx_oe, 1); chk("R6 old mask rx", rx_oe, 1);
    step();
    chk("R4 tx_oe", tx_oe, 0); chk("R4 tx_clav", tx_clav, 0);
    chk("R4 rx_oe", rx_oe, 0); chk("R4 rx_clav", rx_clav, 0);
    tx_addr = 5'd7;
    step();
    chk("R6 unmasked neighbour", tx_oe, 1);
  endtask

  // R7 select, R10 hold while low and while high
  task automatic t_select();
    tx_addr = 5'd5; tx_enb = 1;
    step();
    tx_enb = 0; tx_addr = 5'd31;
    step();
    chk("R7 tx_sv", tx_sv, 1); chk("R7 tx_sp", tx_sp, 5);
    tx_addr = 5'd9;
    step(); step();
    chk("R10 hold low sv", tx_sv, 1); chk("R10 hold low sp", tx_sp, 5);
    tx_enb = 1; tx_addr = 5'd12;
    step(); step();
    chk("R10 hold high sp", tx_sp, 5);
  endtask

  // R8 masked and null previous address
  task automatic t_deselect();
    tx_addr = 5'd6; tx_enb = 1;
    step();
    tx_enb = 0;
    step();
    chk("R8 masked sv", tx_sv, 0); chk("R8 masked sp", tx_sp, 31);
    tx_enb = 1; tx_addr = 5'd3;
    step();
    tx_enb = 0;
    step();
    chk("R7 reselect", tx_sp, 3);
    tx_enb = 1; tx_addr = 5'd31;
    step();
    tx_enb = 0;
    step();
    chk("R8 null sv", tx_sv, 0);
    tx_enb = 1;
  endtask

  task automatic t_independent();
    tx_space = '1; rx_cell = '0;
    rx_enb = 1; rx_addr = 5'd31;
    tx_addr = 5'd4;
    step();
    chk("R9 tx_clav", tx_clav, 1); chk("R9 rx_oe", rx_oe, 0);
    tx_enb = 0;
    step();
    chk("R9 tx_sp", tx_sp, 4); chk("R9 rx_sv", rx_sv, 0); chk("R9 rx_sp", rx_sp, 31);
    rx_addr = 5'd2;
    step();
    chk("R9 rx_clav", rx_clav, 0); chk("R9 rx_oe", rx_oe, 1);
    rx_enb = 0;
    step();
    chk("R9 rx_sp", rx_sp, 2); chk("R9 tx_sp kept", tx_sp, 4);
  endtask

  initial begin
    fork
      begin
        step(); step();
        t_reset();
        rst_ni = 1;
        step();
        t_reset();
        t_all_ports();
        t_null();
        t_mask();
        t_select();
        t_deselect();
        t_independent();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule